// File: doc/BRIEF.md
# Load/Store and Writeback Tail of an Out-of-Order Pipeline

This block is the part of a scoreboarded pipeline that comes after instruction issue. The issue logic pushes memory instructions, together with their base-register and store-data operand values, into a small in-order queue. An address unit pops the oldest queue entry every cycle and forms an effective address. A memory stage then performs a word load or a word store against a local data RAM. Load results, and the results handed in by the arithmetic and logical ALUs, each land in a one-entry post buffer. A writeback stage empties all three post buffers in the same cycle, so up to three register writes commit at once.

No stage in this tail ever stalls. Each stage removes its input at the start of a cycle and writes its output buffer at the end, even when that buffer is occupied at the start, because the consumer below drains it in the same cycle. For every retirement, the writeback stage also drives a per-channel done pulse with the destination index, so the scoreboard can clear that register's pending state. A write aimed at register zero still raises the done pulse, but its register-file write enable stays low.

Top module: `mwb_backend`

## Requirements
- R1: During reset and in the first cycle after it, no writeback channel is active (`wb_done` = 0, `rf_we` = 0) and `mq_count` is 0.
- R2: An instruction whose bits [1:0] are 00 is a store, and any other encoding is a load. The address is the base operand plus a sign-extended 12-bit immediate. For a load the immediate is bits [31:20] and the destination is bits [11:7]. For a store the immediate is bits [31:25] joined above bits [11:7].
- R3: An instruction pushed at clock edge n is counted in `mq_count` after edge n and is taken by the address unit during the following cycle, so `mq_count` is back to 0 after edge n+1 when nothing else is pushed.
- R4: A load pushed at edge n shows up on writeback channel 0 (`wb_done[0]`, `rf_waddr[0]`, `rf_wdata[0]`) in the cycle that follows edge n+2.
- R5: A store writes its data word at the end of its memory-stage cycle and never produces a writeback. A load pushed one cycle after a store to the same address returns the stored word.
- R6: Data words are 32-bit, indexed by (address − `DMEM_BASE`) / 4. A location never written reads as zero.
- R7: An arithmetic result presented with `alu2_valid` is written back on channel 1 in the next cycle. A logical result presented with `alu3_valid` is written back on channel 2 in the next cycle. Destination and value are unchanged.
- R8: All three channels retire in the same cycle when their post buffers are all filled at the same edge.
- R9: Loads pushed on consecutive cycles, and ALU results on consecutive cycles, retire on consecutive cycles without loss, even though each output buffer is occupied when the next result arrives.
- R10: A retirement to register 0 asserts `wb_done` with index 0 and keeps `rf_we` low on that channel.
- R11: Each result raises its channel's `wb_done` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mq_push | input | 1 | Issue pushes a memory instruction this cycle |
| mq_instr | input | 32 | Instruction word of the pushed memory operation |
| mq_base | input | XLEN | Value of the base register |
| mq_sdata | input | XLEN | Value of the store-data register |
| mq_count | output | CNT_W | Memory queue occupancy at the end of the last cycle |
| alu2_valid | input | 1 | Arithmetic ALU has a result this cycle |
| alu2_dest | input | RID_W | Destination index of the arithmetic result |
| alu2_result | input | XLEN | Arithmetic result value |
| alu3_valid | input | 1 | Logical ALU has a result this cycle |
| alu3_dest | input | RID_W | Destination index of the logical result |
| alu3_result | input | XLEN | Logical result value |
| rf_we | output | 3 | Register-file write enable per channel (0 load, 1 arithmetic, 2 logical) |
| rf_waddr | output | 3×RID_W | Register-file write index per channel |
| rf_wdata | output | 3×XLEN | Register-file write data per channel |
| wb_done | output | 3 | Retirement pulse per channel to the scoreboard; the index is on `rf_waddr` |

## Verification
The checker assumes that issue never pushes into a full memory queue. It also assumes that every address reaching the memory stage is word-aligned and falls inside the data window. The stimulus keeps within both assumptions: it pushes at most one memory instruction per cycle, and it picks base and immediate pairs that land on aligned words between `DMEM_BASE` and the top of the RAM. The ALU inputs are treated as pulses that any cycle may carry, and the bench drives them alone and alongside loads so that the channels are seen to be independent.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
   localparam int ILEN     = 32;
   localparam int IMM_W    = 12;
   localparam int NWB      = 3;
   localparam int CH_MEM   = 0;
   localparam int CH_ARITH = 1;
   localparam int CH_LOGIC = 2;
   localparam logic [1:0] CLS_STORE = 2'b00;

   function automatic logic is_store_op(input logic [ILEN-1:0] ins);
      return ins[1:0] == CLS_STORE;
   endfunction

   // stores split the offset across two fields, loads keep it contiguous
   function automatic logic [IMM_W-1:0] mem_offset(input logic [ILEN-1:0] ins);
      if (is_store_op(ins))
         return {ins[31:25], ins[11:7]};
      return ins[31:20];
   endfunction
endpackage

// File: rtl/mwb_fifo.sv
module mwb_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count
);
   logic pop_ok, push_ok;

   assign pop_ok  = pop && (count != '0);
   assign push_ok = push && ((count < CNT_W'(DEPTH)) || pop_ok);

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] hold;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold  <= '0;
            count <= '0;
         end else begin
            if (push_ok) hold <= din;
            count <= CNT_W'(push_ok || (count != '0 && !pop_ok));
         end
      end
      assign dout = hold;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      logic [DEPTH-1:0][W-1:0] slot;
      logic [PTR_W-1:0]        rd_p, wr_p;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot  <= '0;
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
         end else begin
            if (push_ok) begin
               slot[wr_p] <= din;
               wr_p <= (wr_p == PTR_W'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
            end
            if (pop_ok)
               rd_p <= (rd_p == PTR_W'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
         end
      end
      assign dout = slot[rd_p];
   end
endmodule

// File: rtl/mwb_agu.sv
module mwb_agu
   import mwb_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int RID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ILEN-1:0]  in_instr,
   input  logic [XLEN-1:0]  in_base,
   input  logic [XLEN-1:0]  in_sdata,
   output logic             pm_valid,
   output logic             pm_store,
   output logic [RID_W-1:0] pm_dest,
   output logic [XLEN-1:0]  pm_addr,
   output logic [XLEN-1:0]  pm_sdata
);
   logic [IMM_W-1:0] off;
   logic [XLEN-1:0]  off_sx, ea;
   logic             unused_fields;

   assign off    = mem_offset(in_instr);
   assign off_sx = {{(XLEN-IMM_W){off[IMM_W-1]}}, off};
   assign ea     = in_base + off_sx;
   assign unused_fields = ^{in_instr[19:12], in_instr[6:2]};

   // pre-memory buffer: refilled every cycle, MEM always drains it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_valid <= 1'b0;
         pm_store <= 1'b0;
         pm_dest  <= '0;
         pm_addr  <= '0;
         pm_sdata <= '0;
      end else begin
         pm_valid <= in_valid;
         pm_store <= is_store_op(in_instr);
         pm_dest  <= in_instr[7 +: RID_W];
         pm_addr  <= ea;
         pm_sdata <= in_sdata;
      end
   end
endmodule

// File: rtl/mwb_dmem.sv
module mwb_dmem #(
   parameter int          XLEN  = 32,
   parameter int          RID_W = 5,
   parameter int          WORDS = 16,
   parameter int unsigned BASE  = 384,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pm_valid,
   input  logic             pm_store,
   input  logic [RID_W-1:0] pm_dest,
   input  logic [XLEN-1:0]  pm_addr,
   input  logic [XLEN-1:0]  pm_sdata,
   output logic             ld_valid,
   output logic [RID_W-1:0] ld_dest,
   output logic [XLEN-1:0]  ld_data
);
   logic [XLEN-1:0] mem [WORDS];
   logic [XLEN-1:0] rel;
   logic [IDX_W-1:0] idx;
   logic unused_rel;

   assign rel = pm_addr - XLEN'(BASE);
   assign idx = rel[IDX_W+1:2];
   assign unused_rel = ^{rel[XLEN-1:IDX_W+2], rel[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (pm_valid && pm_store) begin
         mem[idx] <= pm_sdata;
      end
   end

   assign ld_valid = pm_valid && !pm_store;
   assign ld_dest  = pm_dest;
   assign ld_data  = mem[idx];
endmodule

// File: rtl/mwb_wb.sv
module mwb_wb
   import mwb_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int RID_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NWB-1:0]             in_v,
   input  logic [NWB-1:0][RID_W-1:0]  in_id,
   input  logic [NWB-1:0][XLEN-1:0]   in_data,
   output logic [NWB-1:0]             rf_we,
   output logic [NWB-1:0][RID_W-1:0]  rf_waddr,
   output logic [NWB-1:0][XLEN-1:0]   rf_wdata,
   output logic [NWB-1:0]             wb_done
);
   for (genvar c = 0; c < NWB; c++) begin : g_post
      logic             v;
      logic [RID_W-1:0] id;
      logic [XLEN-1:0]  d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v  <= 1'b0;
            id <= '0;
            d  <= '0;
         end else begin
            v  <= in_v[c];
            id <= in_id[c];
            d  <= in_data[c];
         end
      end
      assign wb_done[c]  = v;
      assign rf_we[c]    = v && (id != '0);
      assign rf_waddr[c] = id;
      assign rf_wdata[c] = d;
   end
endmodule

// File: rtl/mwb_backend.sv
module mwb_backend
   import mwb_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          NREG       = 32,
   parameter int          MQ_DEPTH   = 2,
   parameter int          DMEM_WORDS = 16,
   parameter int unsigned DMEM_BASE  = 384,
   localparam int RID_W = $clog2(NREG),
   localparam int CNT_W = $clog2(MQ_DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mq_push,
   input  logic [31:0]               mq_instr,
   input  logic [XLEN-1:0]           mq_base,
   input  logic [XLEN-1:0]           mq_sdata,
   output logic [CNT_W-1:0]          mq_count,
   input  logic                      alu2_valid,
   input  logic [RID_W-1:0]          alu2_dest,
   input  logic [XLEN-1:0]           alu2_result,
   input  logic                      alu3_valid,
   input  logic [RID_W-1:0]          alu3_dest,
   input  logic [XLEN-1:0]           alu3_result,
   output logic [2:0]                rf_we,
   output logic [2:0][RID_W-1:0]     rf_waddr,
   output logic [2:0][XLEN-1:0]      rf_wdata,
   output logic [2:0]                wb_done
);
   initial begin : param_chk
      assert (MQ_DEPTH >= 1) else $error("MQ_DEPTH must be at least 1");
      assert (XLEN >= 16) else $error("XLEN too narrow for a 12-bit offset");
      assert (RID_W <= 5) else $error("register index wider than the instruction field");
      assert (DMEM_WORDS >= 2) else $error("DMEM_WORDS must be at least 2");
   end

   typedef struct packed {
      logic [ILEN-1:0] ins;
      logic [XLEN-1:0] base;
      logic [XLEN-1:0] sdata;
   } mq_ent_t;

   mq_ent_t          q_in, q_head;
   logic             q_nonempty;
   logic             pm_valid, pm_store;
   logic [RID_W-1:0] pm_dest;
   logic [XLEN-1:0]  pm_addr, pm_sdata;
   logic             ld_valid;
   logic [RID_W-1:0] ld_dest;
   logic [XLEN-1:0]  ld_data;

   assign q_in       = '{ins: mq_instr, base: mq_base, sdata: mq_sdata};
   assign q_nonempty = (mq_count != '0);

   mwb_fifo #(.W($bits(mq_ent_t)), .DEPTH(MQ_DEPTH)) u_mq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (mq_push),
      .din   (q_in),
      .pop   (q_nonempty),
      .dout  (q_head),
      .count (mq_count)
   );

   mwb_agu #(.XLEN(XLEN), .RID_W(RID_W)) u_agu (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (q_nonempty),
      .in_instr (q_head.ins),
      .in_base  (q_head.base),
      .in_sdata (q_head.sdata),
      .pm_valid (pm_valid),
      .pm_store (pm_store),
      .pm_dest  (pm_dest),
      .pm_addr  (pm_addr),
      .pm_sdata (pm_sdata)
   );

   mwb_dmem #(.XLEN(XLEN), .RID_W(RID_W), .WORDS(DMEM_WORDS), .BASE(DMEM_BASE)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .pm_valid (pm_valid),
      .pm_store (pm_store),
      .pm_dest  (pm_dest),
      .pm_addr  (pm_addr),
      .pm_sdata (pm_sdata),
      .ld_valid (ld_valid),
      .ld_dest  (ld_dest),
      .ld_data  (ld_data)
   );

   mwb_wb #(.XLEN(XLEN), .RID_W(RID_W)) u_wb (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     ({alu3_valid, alu2_valid, ld_valid}),
      .in_id    ({alu3_dest, alu2_dest, ld_dest}),
      .in_data  ({alu3_result, alu2_result, ld_data}),
      .rf_we    (rf_we),
      .rf_waddr (rf_waddr),
      .rf_wdata (rf_wdata),
      .wb_done  (wb_done)
   );
endmodule

// File: rtl/mwb_backend_chk.sv
module mwb_backend_chk #(
   parameter int          XLEN       = 32,
   parameter int          RID_W      = 5,
   parameter int          CNT_W      = 2,
   parameter int          MQ_DEPTH   = 2,
   parameter int          DMEM_WORDS = 16,
   parameter int unsigned DMEM_BASE  = 384
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mq_push,
   input logic [CNT_W-1:0]      mq_count,
   input logic                  alu2_valid,
   input logic [RID_W-1:0]      alu2_dest,
   input logic [XLEN-1:0]       alu2_result,
   input logic                  alu3_valid,
   input logic [RID_W-1:0]      alu3_dest,
   input logic [XLEN-1:0]       alu3_result,
   input logic [2:0]            wb_done,
   input logic [2:0][RID_W-1:0] rf_waddr,
   input logic [2:0][XLEN-1:0]  rf_wdata,
   input logic                  pm_valid,
   input logic                  pm_store,
   input logic [XLEN-1:0]       pm_addr
);
   // R3
   mq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mq_push |-> (mq_count < CNT_W'(MQ_DEPTH)));

   // R3
   agu_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mq_count != '0) |=> pm_valid);

   // R6
   addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_valid |-> (pm_addr[1:0] == 2'b00 &&
                    (pm_addr - XLEN'(DMEM_BASE)) < XLEN'(DMEM_WORDS * 4)));

   // R4
   load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_valid && !pm_store) |=> wb_done[0]);

   // R5
   store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_valid && pm_store) |=> !wb_done[0]);

   // R7
   arith_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu2_valid |=> (wb_done[1] && rf_waddr[1] == $past(alu2_dest) &&
                      rf_wdata[1] == $past(alu2_result)));

   // R7
   logic_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu3_valid |=> (wb_done[2] && rf_waddr[2] == $past(alu3_dest) &&
                      rf_wdata[2] == $past(alu3_result)));

   // R11
   arith_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alu2_valid |=> !wb_done[1]);

   // R11
   logic_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alu3_valid |=> !wb_done[2]);
endmodule

bind mwb_backend mwb_backend_chk #(
   .XLEN(XLEN), .RID_W(RID_W), .CNT_W(CNT_W), .MQ_DEPTH(MQ_DEPTH),
   .DMEM_WORDS(DMEM_WORDS), .DMEM_BASE(DMEM_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mq_push(mq_push), .mq_count(mq_count),
   .alu2_valid(alu2_valid), .alu2_dest(alu2_dest), .alu2_result(alu2_result),
   .alu3_valid(alu3_valid), .alu3_dest(alu3_dest), .alu3_result(alu3_result),
   .wb_done(wb_done), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
   .pm_valid(pm_valid), .pm_store(pm_store), .pm_addr(pm_addr)
);

// File: tb/mwb_backend_bench.sv
module mwb_backend_bench;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN  = 32;
   localparam int RID_W = 5;
   localparam int CNT_W = 2;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  mq_push = 1'b0;
   logic [31:0]           mq_instr = '0;
   logic [XLEN-1:0]       mq_base = '0, mq_sdata = '0;
   logic [CNT_W-1:0]      mq_count;
   logic                  alu2_valid = 1'b0, alu3_valid = 1'b0;
   logic [RID_W-1:0]      alu2_dest = '0, alu3_dest = '0;
   logic [XLEN-1:0]       alu2_result = '0, alu3_result = '0;
   logic [2:0]            rf_we, wb_done;
   logic [2:0][RID_W-1:0] rf_waddr;
   logic [2:0][XLEN-1:0]  rf_wdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mwb_backend u_mwb_backend (
      .clk(clk), .rst_n(rst_n), .mq_push(mq_push), .mq_instr(mq_instr),
      .mq_base(mq_base), .mq_sdata(mq_sdata), .mq_count(mq_count),
      .alu2_valid(alu2_valid), .alu2_dest(alu2_dest), .alu2_result(alu2_result),
      .alu3_valid(alu3_valid), .alu3_dest(alu3_dest), .alu3_result(alu3_result),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .wb_done(wb_done)
   );

   typedef struct packed {
      logic        st;
      logic [4:0]  rd;
      logic [11:0] imm;
      logic [31:0] base;
      logic [31:0] data;
   } vec_t;

   // stores first, then loads reading them back; last entry hits an unwritten word
   localparam vec_t VTAB [7] = '{
      '{1'b1, 5'd0,  12'h000, 32'd384, 32'h1111_1111},
      '{1'b1, 5'd0,  12'hFFC, 32'd400, 32'hFFFF_FFFB},
      '{1'b1, 5'd0,  12'h02C, 32'd384, 32'h7FFF_FFFF},
      '{1'b0, 5'd5,  12'h000, 32'd384, 32'h1111_1111},
      '{1'b0, 5'd9,  12'h00C, 32'd384, 32'hFFFF_FFFB},
      '{1'b0, 5'd31, 12'hFF0, 32'd444, 32'h7FFF_FFFF},
      '{1'b0, 5'd2,  12'h008, 32'd384, 32'h0000_0000}
   };

   function automatic logic [31:0] op_lw(input logic [4:0] rd, input logic [11:0] im);
      return {im, 5'd1, 3'b000, rd, 5'b00101, 2'b10};
   endfunction

   function automatic logic [31:0] op_sw(input logic [11:0] im);
      return {im[11:5], 5'd2, 5'd1, 3'b000, im[4:0], 5'b00011, 2'b00};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic drive_mem(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] sd);
      mq_push = 1'b1; mq_instr = ins; mq_base = b; mq_sdata = sd;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      finish_run();
   end

   initial begin : stim
      // R1 reset state
      repeat (3) tick();
      chk("R1 wb_done in reset", 32'(wb_done), 0);
      chk("R1 rf_we in reset", 32'(rf_we), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 mq_count after reset", 32'(mq_count), 0);
      chk("R1 wb_done after reset", 32'(wb_done), 0);

      // table walk: one memory op at a time (R2, R4, R5, R6)
      foreach (VTAB[i]) begin
         if (VTAB[i].st) drive_mem(op_sw(VTAB[i].imm), VTAB[i].base, VTAB[i].data);
         else            drive_mem(op_lw(VTAB[i].rd, VTAB[i].imm), VTAB[i].base, 32'hDEAD_BEEF);
         tick();
         mq_push = 1'b0;
         tick();
         tick();
         if (VTAB[i].st) begin
            chk("R5 store has no writeback", 32'(wb_done[0]), 0);
         end else begin
            chk("R4 load retires", 32'(wb_done[0]), 1);
            chk("R2 load destination", 32'(rf_waddr[0]), 32'(VTAB[i].rd));
            chk("R2 R6 load data", rf_wdata[0], VTAB[i].data);
         end
         tick();
      end

      // R3 occupancy and drain
      drive_mem(op_lw(5'd8, 12'h000), 32'd384, 0);
      tick();
      mq_push = 1'b0;
      chk("R3 count after push", 32'(mq_count), 1);
      tick();
      chk("R3 count after drain", 32'(mq_count), 0);
      tick();
      chk("R4 load at third edge", 32'(wb_done[0]), 1);
      tick();
      chk("R11 load pulse ends", 32'(wb_done[0]), 0);

      // R5 store then load to the same word on the next cycle
      drive_mem(op_sw(12'h020), 32'd384, 32'hA5A5_0F0F);
      tick();
      drive_mem(op_lw(5'd7, 12'h010), 32'd400, 0);
      tick();
      mq_push = 1'b0;
      tick();
      chk("R5 store slot quiet", 32'(wb_done[0]), 0);
      tick();
      chk("R5 load sees store dest", 32'(rf_waddr[0]), 7);
      chk("R5 load sees store data", rf_wdata[0], 32'hA5A5_0F0F);
      tick();

      // R9 back-to-back loads
      drive_mem(op_lw(5'd3, 12'h000), 32'd384, 0);
      tick();
      drive_mem(op_lw(5'd4, 12'h00C), 32'd384, 0);
      tick();
      drive_mem(op_lw(5'd6, 12'h02C), 32'd384, 0);
      tick();
      mq_push = 1'b0;
      chk("R9 first load data", rf_wdata[0], 32'h1111_1111);
      tick();
      chk("R9 second load dest", 32'(rf_waddr[0]), 4);
      chk("R9 second load data", rf_wdata[0], 32'hFFFF_FFFB);
      tick();
      chk("R9 third load data", rf_wdata[0], 32'h7FFF_FFFF);
      tick();

      // R7 R9 R11 consecutive arithmetic results
      alu2_valid = 1'b1; alu2_dest = 5'd10; alu2_result = 32'd1;
      tick();
      chk("R7 arith dest", 32'(rf_waddr[1]), 10);
      chk("R7 arith data", rf_wdata[1], 1);
      alu2_dest = 5'd11; alu2_result = 32'hFFFF_FFFE;
      tick();
      alu2_valid = 1'b0;
      chk("R9 arith second data", rf_wdata[1], 32'hFFFF_FFFE);
      chk("R9 arith second we", 32'(rf_we[1]), 1);
      tick();
      chk("R11 arith pulse ends", 32'(wb_done[1]), 0);

      // R7 logical channel alone
      alu3_valid = 1'b1; alu3_dest = 5'd20; alu3_result = 32'h00F0_00F0;
      tick();
      alu3_valid = 1'b0;
      chk("R7 logic dest", 32'(rf_waddr[2]), 20);
      chk("R7 logic data", rf_wdata[2], 32'h00F0_00F0);
      chk("R7 logic leaves arith idle", 32'(wb_done[1]), 0);
      tick();

      // R8 three retirements in one cycle
      drive_mem(op_lw(5'd12, 12'h000), 32'd384, 0);
      tick();
      mq_push = 1'b0;
      tick();
      alu2_valid = 1'b1; alu2_dest = 5'd13; alu2_result = 32'h100;
      alu3_valid = 1'b1; alu3_dest = 5'd14; alu3_result = 32'h200;
      tick();
      alu2_valid = 1'b0; alu3_valid = 1'b0;
      chk("R8 all channels done", 32'(wb_done), 32'b111);
      chk("R8 all channels write", 32'(rf_we), 32'b111);
      chk("R8 load data", rf_wdata[0], 32'h1111_1111);
      chk("R8 arith data", rf_wdata[1], 32'h100);
      chk("R8 logic data", rf_wdata[2], 32'h200);
      tick();

      // R10 register zero: done pulses, no write
      drive_mem(op_lw(5'd0, 12'h000), 32'd384, 0);
      tick();
      mq_push = 1'b0;
      tick();
      alu3_valid = 1'b1; alu3_dest = 5'd0; alu3_result = 32'h55;
      tick();
      alu3_valid = 1'b0;
      chk("R10 load to x0 done", 32'(wb_done[0]), 1);
      chk("R10 load to x0 no write", 32'(rf_we[0]), 0);
      chk("R10 load to x0 index", 32'(rf_waddr[0]), 0);
      chk("R10 logic to x0 done", 32'(wb_done[2]), 1);
      chk("R10 logic to x0 no write", 32'(rf_we[2]), 0);
      tick();

      finish_run();
   end
endmodule